// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Boundary-Synchronised Reloads

This block generates one rectangular waveform per channel from a shared clock. Software sets up each channel through a small register port. Each channel has a mode word, which holds a clock-divider exponent and an output inversion bit, and a working period and a working duty count. Each channel also has a staging copy of period and duty. Values written to the staging copies wait there and reach the counter only when the running period wraps, so a live waveform never shows a torn cycle. A global word starts channels, another stops them, a third reports which counters are running, and a fourth collects end-of-period events. Reading the fourth word clears it.

Each period starts at the inactive level. The duty count is the number of divided ticks that the output stays inactive. After that the output is active until the period wraps. A stop request is honoured only when the current period wraps. The output then settles at the inactive level set by the inversion bit.

The register port has no back-pressure. A write strobe completes in the cycle it is asserted. A read strobe returns its data on `bus_rdata` one cycle later, and that data is held until the next read. There is no valid/ready handshake, because nothing flows as a stream: the only outputs are the per-channel waveform pins.

Top module: `pwm_bank`

## Requirements
- R1: Writing address 0x04 with bit n set starts channel n, and writing address 0x08 with bit n set requests a stop of channel n. Zero bits in either write change nothing. Reading 0x0C returns the running flags of the channels in bits [3:0].
- R2: The output is inactive at the start of every period and becomes active once the tick count within the period reaches the duty value. A duty of 0 gives an output that is active for the whole period. A duty equal to or above the period gives an output that is never active.
- R3: Mode bits [3:0] hold an exponent p, and the in-period count advances once every 2^p clocks. Any p above 10 behaves as 10.
- R4: Mode bit 9 set inverts the waveform, so that the active level is 0 and the inactive level is 1. A stopped channel drives its inactive level.
- R5: A write to the duty staging word (bank offset 0x08) or the period staging word (bank offset 0x10) alters the waveform only from the next period onward.
- R6: A stop request takes effect at the end of the current period. Until then, the running flag of the channel reads 1 and the waveform continues unchanged.
- R7: Reading 0x1C returns one bit per channel, and bit n is set once for each period that channel n completes. The same read clears all the bits.
- R8: The working words (mode at bank offset 0x00, duty at 0x04, period at 0x0C) take writes only while their channel is stopped. Writes to them while the channel runs are ignored. Channel n's bank begins at 0x200 + n*0x20.
- R9: The read data appears on `bus_rdata` in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state and for the tick dividers |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 12 | Byte address of the register being accessed |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data |
| pwm_out | output | NUM_CH | Waveform of each channel |

## Verification
The hardest states to reach from the ports are those where a register access lands in the middle of a running period. Two cases matter: a staging write that arrives part-way through a period, and a stop request that must not cut that period short. To reach them, the bench drives the strobes directly inside its sampling loop, on a known phase of the period. It then compares every following clock of the waveform against a model of two consecutive periods. A status read issued while the stop is still pending confirms that the running flag holds until the boundary.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  localparam int unsigned ADDR_W  = 12;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned PRE_W   = 4;
  localparam int unsigned POL_BIT = 9;

  // global words
  localparam logic [ADDR_W-1:0] OFS_START = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_STOP  = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_RUN   = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_EVT   = 12'h01C;

  // per-channel banks
  localparam logic [ADDR_W-1:0] BANK_BASE  = 12'h200;
  localparam int unsigned       BANK_SHIFT = 5;

  localparam logic [BANK_SHIFT-1:0] SLOT_MODE     = 5'h00;
  localparam logic [BANK_SHIFT-1:0] SLOT_DUTY     = 5'h04;
  localparam logic [BANK_SHIFT-1:0] SLOT_DUTY_STG = 5'h08;
  localparam logic [BANK_SHIFT-1:0] SLOT_PER      = 5'h0C;
  localparam logic [BANK_SHIFT-1:0] SLOT_PER_STG  = 5'h10;

  typedef struct packed {
    logic             invert;
    logic [PRE_W-1:0] expo;
  } mode_t;

endpackage

// File: rtl/pwm_tick_div.sv
module pwm_tick_div
  import pwm_pkg::*;
#(
  parameter int unsigned PRE_MAX = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [PRE_W-1:0] expo,
  output logic             tick
);

  localparam int unsigned DIV_W = (PRE_MAX < 1) ? 1 : PRE_MAX;

  logic [PRE_W-1:0] expo_eff;
  logic [DIV_W-1:0] mask;
  logic [DIV_W-1:0] div_q;

  // clamp the exponent; an exponent of DIV_W wraps the shift to zero,
  // which after the decrement yields the all-ones mask it needs
  assign expo_eff = (expo > PRE_W'(PRE_MAX)) ? PRE_W'(PRE_MAX) : expo;
  assign mask     = (DIV_W'(1) << expo_eff) - DIV_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (clear)  div_q <= '0;
    else if (run)    div_q <= div_q + DIV_W'(1);
    else             div_q <= '0;
  end

  assign tick = run && ((div_q & mask) == mask);

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && expo_eff != '0 && !clear) |=> !tick); // R3

endmodule

// File: rtl/pwm_evt_latch.sv
module pwm_evt_latch #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_evt,
  input  logic              rd_clear,
  output logic [NUM_CH-1:0] flags
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (rd_clear ? '0 : flags) | set_evt;
  end

  AST_EVT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt != '0) |=> ((flags & $past(set_evt)) == $past(set_evt))); // R7

  AST_EVT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clear && set_evt == '0) |=> (flags == '0)); // R7

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned PRE_MAX = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             wr_mode,
  input  logic             wr_duty,
  input  logic             wr_duty_stg,
  input  logic             wr_per,
  input  logic             wr_per_stg,
  input  logic [CNT_W-1:0] wval,
  input  mode_t            wmode,
  output logic             running,
  output logic             wave,
  output logic             wrap,
  output mode_t            mode_q,
  output logic [CNT_W-1:0] duty_q,
  output logic [CNT_W-1:0] per_q,
  output logic [CNT_W-1:0] duty_stg_q,
  output logic [CNT_W-1:0] per_stg_q
);

  logic             run_q;
  logic             stop_pend_q;
  logic [CNT_W-1:0] cnt_q;
  logic             duty_pend_q;
  logic             per_pend_q;
  logic             tick;
  logic             launch;
  logic             at_last;
  logic [CNT_W:0]   cnt_next;

  assign launch   = start && !run_q;
  assign cnt_next = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  // a period of zero behaves as a period of one
  assign at_last  = cnt_next >= {1'b0, per_q};
  assign wrap     = run_q && tick && at_last;

  pwm_tick_div #(.PRE_MAX(PRE_MAX)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (launch),
    .run   (run_q),
    .expo  (mode_q.expo),
    .tick  (tick)
  );

  // run control and in-period counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q       <= 1'b0;
      stop_pend_q <= 1'b0;
      cnt_q       <= '0;
    end else if (launch) begin
      run_q       <= 1'b1;
      stop_pend_q <= 1'b0;
      cnt_q       <= '0;
    end else if (run_q) begin
      if (start)     stop_pend_q <= 1'b0;
      else if (stop) stop_pend_q <= 1'b1;
      if (wrap) begin
        cnt_q <= '0;
        if ((stop_pend_q || stop) && !start) begin
          run_q       <= 1'b0;
          stop_pend_q <= 1'b0;
        end
      end else if (tick) begin
        cnt_q <= cnt_next[CNT_W-1:0];
      end
    end
  end

  // mode word: writable only while stopped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                mode_q <= '0;
    else if (wr_mode && !run_q) mode_q <= wmode;
  end

  // duty: direct write while stopped, staged reload at the wrap
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q      <= '0;
      duty_stg_q  <= '0;
      duty_pend_q <= 1'b0;
    end else begin
      if (wrap && duty_pend_q) begin
        duty_q      <= duty_stg_q;
        duty_pend_q <= 1'b0;
      end else if (wr_duty && !run_q) begin
        duty_q <= wval;
      end
      if (wr_duty_stg) begin
        duty_stg_q  <= wval;
        duty_pend_q <= 1'b1;
      end
    end
  end

  // period: direct write while stopped, staged reload at the wrap
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q      <= '0;
      per_stg_q  <= '0;
      per_pend_q <= 1'b0;
    end else begin
      if (wrap && per_pend_q) begin
        per_q      <= per_stg_q;
        per_pend_q <= 1'b0;
      end else if (wr_per && !run_q) begin
        per_q <= wval;
      end
      if (wr_per_stg) begin
        per_stg_q  <= wval;
        per_pend_q <= 1'b1;
      end
    end
  end

  assign running = run_q;
  assign wave    = run_q ? ((cnt_q >= duty_q) ^ mode_q.invert) : mode_q.invert;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && per_q != '0) |-> (cnt_q < per_q)); // R2

  AST_START_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && duty_q != '0) |=> (wave == mode_q.invert)); // R2

  AST_HOLD_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && !$past(wrap)) |-> ($stable(duty_q) && $stable(per_q))); // R5

  AST_RUN_TILL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !wrap) |=> run_q); // R6

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q)) |-> $stable(mode_q)); // R8

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_pkg::*;
#(
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned PRE_MAX = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [11:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);

  logic [ADDR_W-1:0]     bank_rel;
  logic [ADDR_W-1:0]     ch_idx;
  logic [BANK_SHIFT-1:0] slot;
  logic                  in_bank;
  logic                  hit_start;
  logic                  hit_stop;
  logic                  evt_rd;
  mode_t                 wmode;

  logic [NUM_CH-1:0] run_vec;
  logic [NUM_CH-1:0] wrap_vec;
  logic [NUM_CH-1:0] evt_flags;
  mode_t             mode_rb     [NUM_CH];
  logic [CNT_W-1:0]  duty_rb     [NUM_CH];
  logic [CNT_W-1:0]  per_rb      [NUM_CH];
  logic [CNT_W-1:0]  duty_stg_rb [NUM_CH];
  logic [CNT_W-1:0]  per_stg_rb  [NUM_CH];
  logic [DATA_W-1:0] rd_val;

  assign bank_rel  = bus_addr - BANK_BASE;
  assign ch_idx    = bank_rel >> BANK_SHIFT;
  assign slot      = bank_rel[BANK_SHIFT-1:0];
  assign in_bank   = (bus_addr >= BANK_BASE) && (ch_idx < ADDR_W'(NUM_CH));
  assign hit_start = bus_wr && (bus_addr == OFS_START);
  assign hit_stop  = bus_wr && (bus_addr == OFS_STOP);
  assign evt_rd    = bus_rd && (bus_addr == OFS_EVT);
  assign wmode     = '{invert: bus_wdata[POL_BIT], expo: bus_wdata[PRE_W-1:0]};

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
    logic sel;
    assign sel = bus_wr && in_bank && (ch_idx == ADDR_W'(gi));

    pwm_chan #(.CNT_W(CNT_W), .PRE_MAX(PRE_MAX)) u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (hit_start && bus_wdata[gi]),
      .stop        (hit_stop && bus_wdata[gi]),
      .wr_mode     (sel && slot == SLOT_MODE),
      .wr_duty     (sel && slot == SLOT_DUTY),
      .wr_duty_stg (sel && slot == SLOT_DUTY_STG),
      .wr_per      (sel && slot == SLOT_PER),
      .wr_per_stg  (sel && slot == SLOT_PER_STG),
      .wval        (bus_wdata[CNT_W-1:0]),
      .wmode       (wmode),
      .running     (run_vec[gi]),
      .wave        (pwm_out[gi]),
      .wrap        (wrap_vec[gi]),
      .mode_q      (mode_rb[gi]),
      .duty_q      (duty_rb[gi]),
      .per_q       (per_rb[gi]),
      .duty_stg_q  (duty_stg_rb[gi]),
      .per_stg_q   (per_stg_rb[gi])
    );
  end

  pwm_evt_latch #(.NUM_CH(NUM_CH)) u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_evt  (wrap_vec),
    .rd_clear (evt_rd),
    .flags    (evt_flags)
  );

  always_comb begin
    rd_val = '0;
    if (bus_addr == OFS_RUN)      rd_val[NUM_CH-1:0] = run_vec;
    else if (bus_addr == OFS_EVT) rd_val[NUM_CH-1:0] = evt_flags;
    else if (in_bank) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (ch_idx == ADDR_W'(i)) begin
          case (slot)
            SLOT_MODE: begin
              rd_val[PRE_W-1:0] = mode_rb[i].expo;
              rd_val[POL_BIT]   = mode_rb[i].invert;
            end
            SLOT_DUTY:     rd_val[CNT_W-1:0] = duty_rb[i];
            SLOT_DUTY_STG: rd_val[CNT_W-1:0] = duty_stg_rb[i];
            SLOT_PER:      rd_val[CNT_W-1:0] = per_rb[i];
            SLOT_PER_STG:  rd_val[CNT_W-1:0] = per_stg_rb[i];
            default:       rd_val = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  AST_RUN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFS_RUN) |=> (bus_rdata[NUM_CH-1:0] == $past(run_vec))); // R1

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R9

endmodule

// File: tb/pwm_bank_bench.sv
module pwm_bank_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;

  typedef struct packed {
    logic [15:0] per;
    logic [15:0] duty;
    logic        inv;
    logic [3:0]  expo;
    logic [15:0] ones;
  } vec_t;

  // period, duty, invert, exponent, expected count of high samples in one period
  localparam vec_t VEC [NVEC] = '{
    '{16'd8,  16'd3, 1'b0, 4'd0, 16'd5},
    '{16'd10, 16'd0, 1'b0, 4'd0, 16'd10},
    '{16'd6,  16'd6, 1'b0, 4'd0, 16'd0},
    '{16'd6,  16'd9, 1'b0, 4'd0, 16'd0},
    '{16'd5,  16'd2, 1'b1, 4'd0, 16'd2},
    '{16'd4,  16'd1, 1'b0, 4'd2, 16'd12}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [31:0] rdata;
  logic [3:0]  pout;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_bank u_pwm_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (addr),
    .bus_wdata (wdata),
    .bus_wr    (wr),
    .bus_rd    (rd),
    .bus_rdata (rdata),
    .pwm_out   (pout)
  );

  function automatic logic [11:0] chreg(int ch, int ofs);
    return 12'(32'h200 + ch * 32'h20 + ofs);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int mism;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    check(pout == 4'h0, "R4 reset level", int'(pout), 0);
    bus_read(12'h00C, d);
    check(d == 0, "R1 reset run flags", int'(d), 0);
    bus_read(12'h01C, d);
    check(d == 0, "R7 reset events", int'(d), 0);

    // R1: zero bits start nothing
    bus_write(12'h004, 32'h0);
    bus_read(12'h00C, d);
    check(d == 0, "R1 zero start write", int'(d), 0);

    // vector table on channel 0
    foreach (VEC[v]) begin
      int ones;
      int span;
      logic first;
      bit exp_first;
      span = int'(VEC[v].per) << VEC[v].expo;
      bus_write(chreg(0, 'h00), (32'(VEC[v].inv) << 9) | 32'(VEC[v].expo));
      bus_write(chreg(0, 'h0C), 32'(VEC[v].per));
      bus_write(chreg(0, 'h04), 32'(VEC[v].duty));
      bus_write(12'h004, 32'h1);
      ones = 0;
      first = pout[0];
      for (int k = 0; k < span; k++) begin
        if (pout[0]) ones++;
        @(negedge clk);
      end
      check(ones == int'(VEC[v].ones), "R2/R3/R4 high count", ones, int'(VEC[v].ones));
      exp_first = (VEC[v].duty != 0) ? VEC[v].inv : !VEC[v].inv;
      check(first == exp_first, "R2 first sample level", int'(first), int'(exp_first));
      bus_write(12'h008, 32'h1);
      repeat (span + 4) @(negedge clk);
      bus_read(12'h00C, d);
      check(d[0] == 1'b0, "R6 stopped after wrap", int'(d[0]), 0);
      check(pout[0] == VEC[v].inv, "R4 stopped level", int'(pout[0]), int'(VEC[v].inv));
      bus_read(12'h01C, d);
    end

    // R9/R8: registered readback of a direct write
    bus_read(chreg(0, 'h0C), d);
    check(d == 4, "R9 period readback", int'(d), 4);

    // R5: staged duty written mid-period on channel 1
    bus_write(chreg(1, 'h00), 32'h0);
    bus_write(chreg(1, 'h0C), 32'd10);
    bus_write(chreg(1, 'h04), 32'd5);
    bus_write(12'h004, 32'h2);
    mism = 0;
    for (int i = 0; i < 20; i++) begin
      bit e;
      e = ((i % 10) >= ((i < 10) ? 5 : 2));
      if (pout[1] != e) mism++;
      if (i == 3) begin addr = chreg(1, 'h08); wdata = 32'd2; wr = 1'b1; end
      if (i == 4) wr = 1'b0;
      @(negedge clk);
    end
    check(mism == 0, "R5 staged duty at wrap", mism, 0);
    bus_write(12'h008, 32'h2);
    repeat (14) @(negedge clk);
    bus_read(chreg(1, 'h04), d);
    check(d == 2, "R5 duty after reload", int'(d), 2);
    bus_read(12'h01C, d);

    // R6: stop requested early in a period on channel 2
    bus_write(chreg(2, 'h00), 32'h0);
    bus_write(chreg(2, 'h0C), 32'd12);
    bus_write(chreg(2, 'h04), 32'd0);
    bus_write(12'h004, 32'h4);
    mism = 0;
    for (int i = 0; i < 15; i++) begin
      bit e;
      e = (i < 12);
      if (pout[2] != e) mism++;
      if (i == 2) begin addr = 12'h008; wdata = 32'h4; wr = 1'b1; end
      if (i == 3) begin wr = 1'b0; addr = 12'h00C; rd = 1'b1; end
      if (i == 4) begin
        rd = 1'b0;
        check(rdata[2] == 1'b1, "R6 flag held while pending", int'(rdata[2]), 1);
      end
      @(negedge clk);
    end
    check(mism == 0, "R6 waveform until wrap", mism, 0);

    // R7: one completed period, read clears
    bus_read(12'h01C, d);
    check(d == 32'h4, "R7 event bit", int'(d), 4);
    bus_read(12'h01C, d);
    check(d == 0, "R7 cleared by read", int'(d), 0);

    // R8: direct writes ignored while running on channel 3
    bus_write(chreg(3, 'h00), 32'h0);
    bus_write(chreg(3, 'h0C), 32'd4);
    bus_write(chreg(3, 'h04), 32'd4);
    bus_write(12'h004, 32'h8);
    bus_write(chreg(3, 'h04), 32'd0);
    bus_write(chreg(3, 'h00), 32'h200);
    mism = 0;
    for (int i = 0; i < 8; i++) begin
      if (pout[3] != 1'b0) mism++;
      @(negedge clk);
    end
    check(mism == 0, "R8 waveform unchanged", mism, 0);
    bus_read(chreg(3, 'h04), d);
    check(d == 4, "R8 duty kept", int'(d), 4);
    bus_write(12'h008, 32'h8);
    repeat (8) @(negedge clk);
    bus_read(12'h01C, d);

    // R3: exponent above the limit behaves as the limit
    bus_write(chreg(0, 'h00), 32'hF);
    bus_write(chreg(0, 'h0C), 32'd2);
    bus_write(chreg(0, 'h04), 32'd1);
    bus_write(12'h004, 32'h1);
    for (int k = 0; k < 1026; k++) begin
      if (k == 1023) check(pout[0] == 1'b0, "R3 clamp low phase", int'(pout[0]), 0);
      if (k == 1024) check(pout[0] == 1'b1, "R3 clamp high phase", int'(pout[0]), 1);
      @(negedge clk);
    end
    bus_write(12'h008, 32'h1);
    repeat (2100) @(negedge clk);

    // R1: multi-bit start
    bus_write(12'h004, 32'hA);
    bus_read(12'h00C, d);
    check(d == 32'hA, "R1 multi-bit start", int'(d), 10);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule